// File: doc/BRIEF.md
# SPI Serial Memory Slave Front End

This block is the serial-bus slave side of a memory device. It watches an SPI clock, an active-low select, a data input and an optional hold line. Command, address and data bits are gathered into bytes and handed to a memory back end as one-cycle strobes. Read bytes fetched from the back end are shifted out on a serial output. The output is accompanied by an enable, so the pad can float it. All four bus inputs are oversampled by a faster system clock through synchronizers, so the whole block runs in one clock domain.

The edge on which read data changes is chosen by a configuration input. One multi-function pin can be left unused, act as a hold input that freezes the transfer, or report ready/busy from the array. After reset the block stays deaf until the select line has gone from low to high once. The command set and the array are outside the block. The back end sees a byte strobe on the receive side and a request/response pair on the transmit side.

Top module: `spi_mem_front`

## Requirements
- R1: Serial input bits are taken on each rising SCK edge, most significant bit first. After every eighth taken edge, `rx_valid` pulses for one clock with the assembled byte on `rx_byte`.
- R2: `rx_first` is high together with the first `rx_valid` of each select-low frame and low for every later byte of that frame.
- R3: From reset until `cs_n` has been seen to go from low to high once, no byte is strobed, no read request is made and `so_oe` stays low.
- R4: `so_oe` is low whenever the synchronized `cs_n` is high or hold is active. Otherwise, once armed, it is high while selected.
- R5: Raising `cs_n` in the middle of a byte discards the partial bits. The next frame starts bit counting afresh.
- R6: With `cfg_rd_rise`=0, the first read byte's MSB is on `so_out` before the first rising SCK edge. Each following bit, MSB first, appears after a falling SCK edge.
- R7: With `cfg_rd_rise`=1, `so_out` changes only after rising SCK edges. The first byte's MSB appears after the first rising edge of the frame.
- R8: `rd_req` pulses once at each frame start and once more per byte, when the byte's last bit is driven. `rd_data` must hold the requested byte from the clock after `rd_req` is seen high. A frame of n whole bytes makes n+1 requests, and byte j of the frame is the response to request j.
- R9: `cfg_pin_mode` encoding: 2'b00 leaves the pin unused, 2'b01 makes it a hold input, 2'b10 makes it a ready/busy output, and 2'b11 acts as unused. In any mode other than 2'b01, `mf_in` has no effect on transfers.
- R10: While hold is active (mode 2'b01 and `mf_in` low), SCK edges are ignored and both bit positions are kept. The transfer resumes intact when `mf_in` returns high.
- R11: In mode 2'b10, `mf_oe` is high and `mf_out` is the inverse of `busy_i`, registered one clock. In other modes, `mf_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than SCK |
| rst_n | input | 1 | Active-low reset |
| sck | input | 1 | SPI serial clock |
| cs_n | input | 1 | Active-low select |
| si | input | 1 | Serial data in |
| so_out | output | 1 | Serial data out value |
| so_oe | output | 1 | Serial data out enable (low = high impedance) |
| mf_in | input | 1 | Multi-function pin input (hold, active low) |
| mf_out | output | 1 | Multi-function pin output value (ready high) |
| mf_oe | output | 1 | Multi-function pin output enable |
| cfg_pin_mode | input | 2 | Multi-function pin mode |
| cfg_rd_rise | input | 1 | 1: read data changes on rising SCK |
| busy_i | input | 1 | Array programming in progress |
| rx_valid | output | 1 | Received byte strobe |
| rx_byte | output | W | Received byte |
| rx_first | output | 1 | Byte is the first of its frame |
| rd_req | output | 1 | Request next read byte |
| rd_data | input | W | Read byte from back end |

## Verification
Seeded random frames of one to four bytes mix random input bytes with both read-edge settings. This separates an edge-selection or bit-order fault from a byte-boundary fault, because each frame is compared bit by bit in both directions. Directed frames cover several cases that random traffic rarely reaches. One clocks bytes before the first select release, to show that arming is needed. Another aborts a frame mid-byte, which exposes bit-counter reset faults. A third inserts a hold pause with junk SCK edges, which shows whether edges leak through hold. A low `mf_in` in the unused mode shows the hold gating depends on the mode. Ready/busy is toggled in each pin mode.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
   typedef enum logic [1:0] {
      PIN_NC   = 2'b00,
      PIN_HOLD = 2'b01,
      PIN_RDY  = 2'b10,
      PIN_RSVD = 2'b11
   } pin_mode_e;
endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
   parameter int          W       = 4,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stg[0] <= RST_VAL;
            else        stg[0] <= d;
      end else begin : g_tail
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stg[s] <= RST_VAL;
            else        stg[s] <= stg[s-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_fe_rx.sv
module spi_fe_rx #(
   parameter int W  = 8,
   parameter int CW = $clog2(W)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          take,
   input  logic          bit_in,
   output logic          valid,
   output logic [W-1:0]  data,
   output logic          first,
   output logic [CW-1:0] bit_cnt
);
   localparam logic [CW-1:0] LAST = CW'(W-1);

   logic [W-1:0] sh;
   logic         first_pend;
   logic [W-1:0] sh_next;

   assign sh_next = {sh[W-2:0], bit_in};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh <= '0; bit_cnt <= '0; valid <= 1'b0;
         data <= '0; first <= 1'b0; first_pend <= 1'b1;
      end else begin
         valid <= 1'b0;
         if (clr) begin
            bit_cnt    <= '0;
            first_pend <= 1'b1;
         end else if (take) begin
            sh <= sh_next;
            if (bit_cnt == LAST) begin
               bit_cnt    <= '0;
               valid      <= 1'b1;
               data       <= sh_next;
               first      <= first_pend;
               first_pend <= 1'b0;
            end else begin
               bit_cnt <= bit_cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/spi_fe_tx.sv
module spi_fe_tx #(
   parameter int W  = 8,
   parameter int CW = $clog2(W)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         step,
   input  logic         rd_rise,
   input  logic [W-1:0] rd_data,
   output logic         rd_req,
   output logic         so_bit
);
   localparam logic [CW-1:0] LAST = CW'(W-1);
   localparam logic [CW-1:0] PREF = CW'(W-2);

   logic [W-1:0]  tx_sr, nxt;
   logic [CW-1:0] cnt;
   logic          pend, ld_first, skip;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sr <= '0; nxt <= '0; cnt <= '0;
         pend <= 1'b0; ld_first <= 1'b0; skip <= 1'b0; rd_req <= 1'b0;
      end else begin
         rd_req <= 1'b0;
         pend   <= rd_req;
         if (pend) begin
            nxt <= rd_data;
            if (ld_first) begin
               tx_sr    <= rd_data;
               ld_first <= 1'b0;
            end
         end
         if (start) begin
            rd_req   <= 1'b1;
            ld_first <= 1'b1;
            cnt      <= '0;
            skip     <= rd_rise;
         end else if (step) begin
            if (skip) begin
               skip <= 1'b0;
            end else if (cnt == LAST) begin
               tx_sr <= nxt;
               cnt   <= '0;
            end else begin
               tx_sr <= {tx_sr[W-2:0], 1'b0};
               cnt   <= cnt + 1'b1;
               if (cnt == PREF) rd_req <= 1'b1;
            end
         end
      end
   end

   assign so_bit = tx_sr[W-1];
endmodule

// File: rtl/spi_mem_front.sv
module spi_mem_front
   import spi_fe_pkg::*;
#(
   parameter int W           = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit HAS_MF_PIN  = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sck,
   input  logic         cs_n,
   input  logic         si,
   output logic         so_out,
   output logic         so_oe,
   input  logic         mf_in,
   output logic         mf_out,
   output logic         mf_oe,
   input  logic [1:0]   cfg_pin_mode,
   input  logic         cfg_rd_rise,
   input  logic         busy_i,
   output logic         rx_valid,
   output logic [W-1:0] rx_byte,
   output logic         rx_first,
   output logic         rd_req,
   input  logic [W-1:0] rd_data
);
   localparam int CW = $clog2(W);

   if (W < 2)           begin : g_bad_w    $error("W must be at least 2");           end
   if (SYNC_STAGES < 2) begin : g_bad_sync $error("SYNC_STAGES must be at least 2"); end

   logic [3:0] sync_q;
   logic       mf_s, cs_s, sck_s, si_s;
   logic       sck_prev, cs_prev, armed;
   logic       hold_act, active, frame_start;
   logic       step;
   pin_mode_e  mode;

   assign mode = pin_mode_e'(cfg_pin_mode);

   spi_fe_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1100)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({mf_in, cs_n, sck, si}), .q(sync_q));
   assign {mf_s, cs_s, sck_s, si_s} = sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_prev <= 1'b0; cs_prev <= 1'b1; armed <= 1'b0; so_oe <= 1'b0;
      end else begin
         sck_prev <= sck_s;
         cs_prev  <= cs_s;
         if (cs_s && !cs_prev) armed <= 1'b1;
         so_oe <= active;
      end
   end

   if (HAS_MF_PIN) begin : g_mf
      assign hold_act = (mode == PIN_HOLD) && !mf_s;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mf_oe <= 1'b0; mf_out <= 1'b0;
         end else begin
            mf_oe  <= (mode == PIN_RDY);
            mf_out <= (mode == PIN_RDY) && !busy_i;
         end
      end
   end else begin : g_no_mf
      assign hold_act = 1'b0;
      assign mf_oe    = 1'b0;
      assign mf_out   = 1'b0;
   end

   assign active      = armed && !cs_s && !hold_act;
   assign frame_start = armed && !cs_s && cs_prev;
   assign step        = active && (cfg_rd_rise ? (sck_s && !sck_prev)
                                               : (!sck_s && sck_prev));

   spi_fe_rx #(.W(W), .CW(CW)) u_rx (
      .clk(clk), .rst_n(rst_n), .clr(cs_s || !armed),
      .take(active && sck_s && !sck_prev), .bit_in(si_s),
      .valid(rx_valid), .data(rx_byte), .first(rx_first), .bit_cnt());

   spi_fe_tx #(.W(W), .CW(CW)) u_tx (
      .clk(clk), .rst_n(rst_n), .start(frame_start), .step(step),
      .rd_rise(cfg_rd_rise), .rd_data(rd_data), .rd_req(rd_req), .so_bit(so_out));
endmodule

// File: rtl/spi_mem_front_chk.sv
module spi_mem_front_chk #(
   parameter int W  = 8,
   parameter int CW = $clog2(W)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cs_s,
   input logic          armed,
   input logic          hold_act,
   input logic [CW-1:0] bit_cnt,
   input logic          rx_valid,
   input logic          rd_req,
   input logic          so_oe,
   input logic          mf_oe,
   input logic          mf_out,
   input logic          busy_i,
   input logic [1:0]    mode
);
   a_r4_quiet_deselected: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_s || hold_act) |=> !so_oe);
   a_r3_no_byte_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |=> !rx_valid);
   a_r3_no_req_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |=> !rd_req);
   a_r10_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_act && !cs_s) |=> $stable(bit_cnt));
   a_r1_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);
   a_r8_single_req: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> !rd_req);
   a_r11_ready_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b10) |=> (mf_oe && (mf_out == !$past(busy_i))));
   a_r9_pin_released: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != 2'b10) |=> !mf_oe);
endmodule

bind spi_mem_front spi_mem_front_chk #(.W(W), .CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .armed(armed), .hold_act(hold_act),
   .bit_cnt(u_rx.bit_cnt), .rx_valid(rx_valid), .rd_req(rd_req), .so_oe(so_oe),
   .mf_oe(mf_oe), .mf_out(mf_out), .busy_i(busy_i), .mode(cfg_pin_mode));

// File: tb/spi_mem_front_bench.sv
module spi_mem_front_bench;
   localparam int HALF = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic sck = 1'b0, cs_n = 1'b0, si = 1'b0, mf_in = 1'b1;
   logic [1:0] cfg_pin_mode = 2'b00;
   logic cfg_rd_rise = 1'b0, busy_i = 1'b0;
   logic so_out, so_oe, mf_out, mf_oe, rx_valid, rx_first, rd_req;
   logic [7:0] rx_byte, rd_data;

   int errors = 0, checks = 0;
   int req_cnt = 0, rx_n = 0;
   logic [7:0] rx_buf [0:15];
   logic       rx_fst [0:15];
   logic [7:0] tx_byte [0:7];
   logic [7:0] got_byte [0:7];

   always #4 clk = ~clk;

   spi_mem_front u_spi_mem_front (
      .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
      .so_out(so_out), .so_oe(so_oe), .mf_in(mf_in), .mf_out(mf_out), .mf_oe(mf_oe),
      .cfg_pin_mode(cfg_pin_mode), .cfg_rd_rise(cfg_rd_rise), .busy_i(busy_i),
      .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_first(rx_first),
      .rd_req(rd_req), .rd_data(rd_data));

   function automatic logic [7:0] pat(int k);
      return 8'(k * 59 + 90) ^ 8'(k >> 3);
   endfunction

   // back end model: answers each request at the edge it is seen
   always @(posedge clk) begin
      if (!rst_n) rd_data <= 8'h00;
      else if (rd_req) begin
         rd_data <= pat(req_cnt);
         req_cnt <= req_cnt + 1;
      end
   end

   always @(negedge clk) begin
      if (rx_valid && rx_n < 16) begin
         rx_buf[rx_n] = rx_byte;
         rx_fst[rx_n] = rx_first;
         rx_n = rx_n + 1;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bit_xfer(input logic b, output logic got);
      si = b;
      idle(HALF);
      if (!cfg_rd_rise) got = so_out;
      sck = 1'b1;
      idle(HALF);
      if (cfg_rd_rise) got = so_out;
      sck = 1'b0;
   endtask

   task automatic hold_pause();
      logic junk;
      mf_in = 1'b0;
      idle(6);
      chk("R4 so_oe during hold", so_oe, 0);
      for (int k = 0; k < 3; k++) begin
         si = $urandom();
         idle(HALF); sck = 1'b1; idle(HALF); sck = 1'b0;
      end
      junk = 1'b0;
      mf_in = 1'b1;
      idle(6);
   endtask

   // one frame of n bytes; hold pause before bit index hold_at (-1: none)
   task automatic frame(input int n, input int hold_at, input string tag);
      int base;
      logic g;
      rx_n = 0;
      base = req_cnt;
      cs_n = 1'b0;
      idle(8);
      for (int j = 0; j < n; j++) begin
         for (int b = 7; b >= 0; b--) begin
            if (j * 8 + (7 - b) == hold_at) hold_pause();
            bit_xfer(tx_byte[j][b], g);
            got_byte[j][b] = g;
         end
      end
      idle(HALF);
      chk({tag, " R4 so_oe while selected"}, so_oe, 1);
      cs_n = 1'b1;
      idle(10);
      chk({tag, " R1 byte count"}, rx_n, n);
      chk({tag, " R4 so_oe after deselect"}, so_oe, 0);
      chk({tag, " R8 request count"}, req_cnt - base, n + 1);
      for (int j = 0; j < n && j < rx_n; j++) begin
         chk({tag, " R1 rx byte"}, rx_buf[j], tx_byte[j]);
         chk({tag, " R2 first flag"}, rx_fst[j], (j == 0) ? 1 : 0);
         chk({tag, cfg_rd_rise ? " R7 read byte" : " R6 read byte"},
             got_byte[j], pat(base + j));
      end
   endtask

   initial begin
      logic g;
      void'($urandom(32'd1941));
      idle(5);
      chk("R3 reset so_oe", so_oe, 0);
      chk("R1 reset rx_valid", rx_valid, 0);
      chk("R8 reset rd_req", rd_req, 0);
      chk("R11 reset mf_oe", mf_oe, 0);
      rst_n = 1'b1;
      idle(6);
      // R3: clocking with select low before any release is ignored
      for (int b = 0; b < 8; b++) bit_xfer(1'b1, g);
      idle(6);
      chk("R3 no byte before arming", rx_n, 0);
      chk("R3 no request before arming", req_cnt, 0);
      chk("R3 so_oe before arming", so_oe, 0);
      cs_n = 1'b1;
      idle(10);

      // directed: fixed bytes, both edges
      tx_byte[0] = 8'hA5; tx_byte[1] = 8'h01; tx_byte[2] = 8'h80;
      cfg_rd_rise = 1'b0; frame(3, -1, "dir_fall");
      cfg_rd_rise = 1'b1; frame(3, -1, "dir_rise");

      // R5: abort mid-byte then a clean frame
      cfg_rd_rise = 1'b0;
      rx_n = 0;
      cs_n = 1'b0; idle(8);
      for (int b = 0; b < 5; b++) bit_xfer(1'b1, g);
      cs_n = 1'b1; idle(10);
      chk("R5 no byte from partial", rx_n, 0);
      tx_byte[0] = 8'h3C;
      frame(1, -1, "R5 after abort");

      // R10: hold pause mid-byte, both edges
      cfg_pin_mode = 2'b01;
      tx_byte[0] = 8'h96; tx_byte[1] = 8'h5E;
      frame(2, 4, "R10 hold fall");
      cfg_rd_rise = 1'b1;
      frame(2, 11, "R10 hold rise");

      // R9: unused mode ignores a low mf_in
      cfg_pin_mode = 2'b00; cfg_rd_rise = 1'b0;
      mf_in = 1'b0;
      tx_byte[0] = 8'hC3;
      frame(1, -1, "R9 unused pin");
      mf_in = 1'b1;
      cfg_pin_mode = 2'b11;
      mf_in = 1'b0;
      tx_byte[0] = 8'h7E;
      frame(1, -1, "R9 reserved pin");
      mf_in = 1'b1;

      // R11: ready/busy
      cfg_pin_mode = 2'b10; busy_i = 1'b1; idle(3);
      chk("R11 busy mf_oe", mf_oe, 1);
      chk("R11 busy mf_out", mf_out, 0);
      busy_i = 1'b0; idle(3);
      chk("R11 ready mf_out", mf_out, 1);
      cfg_pin_mode = 2'b01; idle(3);
      chk("R11 hold mode mf_oe", mf_oe, 0);
      cfg_pin_mode = 2'b00;

      // random frames
      for (int f = 0; f < 24; f++) begin
         int n;
         n = 1 + int'($urandom_range(3));
         cfg_rd_rise = 1'($urandom());
         for (int j = 0; j < n; j++) tx_byte[j] = 8'($urandom());
         frame(n, -1, "rand");
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule